// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter

This block moves packets from a byte-wide transmit queue onto a single serial data line, one bit per serial clock tick, most significant bit first. Each packet is one frame. A frame begins only when the frame sync/enable input allows it, and the first data bit follows that start by a programmable number of ticks. A line strobe marks every tick on which a valid bit is on the line. The serial clock is presented as two single-cycle tick inputs, one for each edge of the serial clock. A configuration bit picks which of the two drives the shifter.

Software drives the block with single-cycle command pulses. Enable starts a transmitter that is held in reset or paused. Reset aborts the transmitter at once. Pause stops it at the next packet boundary and leaves any later packet in the queue. The static configuration is kept across a reset command: shift edge, sync polarity, strobe polarity, level or edge frame start, and start delay. If the queue runs dry inside a packet, the line goes idle, a sticky underrun flag is raised, and the packet continues once data arrives.

Top module: `sstx_top`

## Requirements
- R1: After rst_n or a reset command, tx_state reads 00 (reset), tx_strobe is at its inactive level, tx_data is 0 and tx_underrun is 0.
- R2: cmd_enable moves tx_state from 00 (reset) or 11 (paused) to 01 (idle). In idle (01) or active (10) it has no effect, and an active packet continues bit for bit.
- R3: With cfg_clk_inv=0 only sclk_rise advances the transmitter. With cfg_clk_inv=1 only sclk_fall does. A tick on the other input changes nothing.
- R4: With cfg_edge_start=0, a tick in idle that sees sync active and the queue non-empty starts a frame. With cfg_edge_start=1, sync must also have been inactive on the previous tick. Sync held active with no inactive tick before it never starts a frame.
- R5: Sync is active when frame_sync differs from cfg_sync_low (0: active high, 1: active low).
- R6: With cfg_delay=D, the first bit of a frame is on tx_data D ticks after the start tick. With D=0 it appears after the start tick itself. Once started, tx_state reads 10 (active).
- R7: Bytes are sent MSB first and back to back, with the strobe active on every data tick. On the tick after the last bit of the byte flagged fifo_eop, the strobe goes inactive, tx_data goes to 0, and tx_state returns to 01.
- R8: tx_strobe is high when active if cfg_strobe_low=0, and low when active if cfg_strobe_low=1.
- R9: If a packet needs its next byte on a tick and the queue is empty, the strobe goes inactive and tx_data goes to 0. tx_underrun becomes 1 and stays 1 until a reset. tx_state stays 10, and sending resumes on the first tick that finds data.
- R10: cmd_pause in active (10) lets the current packet finish. On its end tick, tx_state becomes 11 instead of 01. This also holds when the pause falls on that same end tick. No later byte is popped while paused.
- R11: cmd_pause in idle (01) moves tx_state to 11 on the next clock, and no frame starts in that cycle.
- R12: After cmd_enable in paused, the next frame start sends the packet left at the head of the queue.
- R13: A reset command aborts an active frame at once and wins over enable or pause in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_rise | input | 1 | Tick for a rising serial clock edge |
| sclk_fall | input | 1 | Tick for a falling serial clock edge |
| cfg_clk_inv | input | 1 | Shift edge select (0 rising, 1 falling) |
| cfg_sync_low | input | 1 | Sync polarity (1 = active low) |
| cfg_strobe_low | input | 1 | Strobe polarity (1 = active low) |
| cfg_edge_start | input | 1 | Frame start on sync edge (1) or level (0) |
| cfg_delay | input | DLY_W | Ticks from frame start to first bit |
| cmd_enable | input | 1 | Enable command pulse |
| cmd_reset | input | 1 | Transmitter reset command pulse |
| cmd_pause | input | 1 | Pause command pulse |
| frame_sync | input | 1 | Frame sync/enable input |
| fifo_valid | input | 1 | Queue holds a byte |
| fifo_data | input | DATA_W | Byte at the head of the queue |
| fifo_eop | input | 1 | Head byte ends its packet |
| fifo_pop | output | 1 | Consume the head byte this cycle |
| tx_data | output | 1 | Serial data line |
| tx_strobe | output | 1 | Line strobe |
| tx_underrun | output | 1 | Sticky underrun flag |
| tx_state | output | 2 | 00 reset, 01 idle, 10 active, 11 paused |

## Verification
Two coincidences matter most. The first is a pause command on the same cycle as the shift tick that closes an end-of-packet byte. The bench raises cmd_pause in the very cycle of that ninth tick, then expects tx_state 11, an inactive strobe, and the next packet still counted in its queue model. The second is a reset command that arrives together with enable and a tick in the middle of a frame. There the bench expects the reset state with the line quiet and no further pops.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
   typedef enum logic [1:0] {
      ST_RESET  = 2'b00,
      ST_IDLE   = 2'b01,
      ST_ACTIVE = 2'b10,
      ST_PAUSED = 2'b11
   } tx_state_e;
endpackage

// File: rtl/sstx_frame_start.sv
module sstx_frame_start (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sync_in,
   input  logic cfg_sync_low,
   input  logic cfg_edge_start,
   output logic start_ok
);
   logic sync_act;
   logic prev_act;

   assign sync_act = sync_in ^ cfg_sync_low;

   // Reset to "active" so a sync held active out of reset is not an edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prev_act <= 1'b1;
      else if (tick) prev_act <= sync_act;
   end

   assign start_ok = cfg_edge_start ? (sync_act & ~prev_act) : sync_act;
endmodule

// File: rtl/sstx_serializer.sv
module sstx_serializer #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic              clear,
   input  logic [DATA_W-1:0] data_in,
   output logic              line_q,
   output logic              strb_q,
   output logic              empty
);
   localparam int CNT_W = $clog2(DATA_W + 1);

   logic [DATA_W-1:0] shreg;
   logic [CNT_W-1:0]  left;
   logic              first_bit, next_bit;
   logic [DATA_W-1:0] load_rest, shifted;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sstx_serializer: DATA_W must be at least 2");
      end
      if (MSB_FIRST) begin : g_msb
         assign first_bit = data_in[DATA_W-1];
         assign next_bit  = shreg[DATA_W-1];
         assign load_rest = {data_in[DATA_W-2:0], 1'b0};
         assign shifted   = {shreg[DATA_W-2:0], 1'b0};
      end else begin : g_lsb
         assign first_bit = data_in[0];
         assign next_bit  = shreg[0];
         assign load_rest = {1'b0, data_in[DATA_W-1:1]};
         assign shifted   = {1'b0, shreg[DATA_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         left   <= '0;
         line_q <= 1'b0;
         strb_q <= 1'b0;
      end else if (clear) begin
         left   <= '0;
         line_q <= 1'b0;
         strb_q <= 1'b0;
      end else if (load) begin
         shreg  <= load_rest;
         left   <= CNT_W'(DATA_W - 1);
         line_q <= first_bit;
         strb_q <= 1'b1;
      end else if (shift) begin
         shreg  <= shifted;
         left   <= left - 1'b1;
         line_q <= next_bit;
      end
   end

   assign empty = (left == '0);

   a_r7_no_shift_when_empty : assert property (@(posedge clk) disable iff (!rst_n)
      shift |-> !empty);
   a_r7_bit_countdown : assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !clear && !load) |=> (left == CNT_W'($past(left) - 1'b1)));
endmodule

// File: rtl/sstx_ctrl.sv
module sstx_ctrl
   import sstx_pkg::*;
#(
   parameter int DLY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cmd_enable,
   input  logic             cmd_reset,
   input  logic             cmd_pause,
   input  logic [DLY_W-1:0] cfg_delay,
   input  logic             start_ok,
   input  logic             fifo_valid,
   input  logic             fifo_eop,
   input  logic             ser_empty,
   output tx_state_e        state_q,
   output logic             load,
   output logic             shift,
   output logic             clear,
   output logic             fifo_pop,
   output logic             underrun_q
);
   logic             pause_pend, in_delay, cur_eop;
   logic [DLY_W-1:0] dly_cnt;
   logic             st_idle, st_active, body, start, need_byte, finish, starve;

   generate
      if (DLY_W < 1) begin : g_bad_dly
         $error("sstx_ctrl: DLY_W must be at least 1");
      end
   endgenerate

   assign st_idle   = (state_q == ST_IDLE);
   assign st_active = (state_q == ST_ACTIVE);
   assign body      = st_active & ~in_delay;
   assign start     = tick & st_idle & start_ok & fifo_valid & ~cmd_pause & ~cmd_reset;
   assign need_byte = tick & body & ser_empty & ~cur_eop;
   assign load      = ~cmd_reset & ((start & (cfg_delay == '0))
                    | (tick & st_active & in_delay & (dly_cnt == DLY_W'(1)))
                    | (need_byte & fifo_valid));
   assign shift     = ~cmd_reset & tick & body & ~ser_empty;
   assign finish    = ~cmd_reset & tick & body & ser_empty & cur_eop;
   assign starve    = ~cmd_reset & need_byte & ~fifo_valid;
   assign clear     = cmd_reset | finish | starve;
   assign fifo_pop  = load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_RESET;
         pause_pend <= 1'b0;
         in_delay   <= 1'b0;
         dly_cnt    <= '0;
         cur_eop    <= 1'b0;
         underrun_q <= 1'b0;
      end else if (cmd_reset) begin
         state_q    <= ST_RESET;
         pause_pend <= 1'b0;
         in_delay   <= 1'b0;
         cur_eop    <= 1'b0;
         underrun_q <= 1'b0;
      end else begin
         if (load) cur_eop <= fifo_eop;
         unique case (state_q)
            ST_RESET, ST_PAUSED: begin
               if (cmd_enable) state_q <= ST_IDLE;
            end
            ST_IDLE: begin
               if (cmd_pause) begin
                  state_q <= ST_PAUSED;
               end else if (start) begin
                  state_q  <= ST_ACTIVE;
                  in_delay <= (cfg_delay != '0);
                  dly_cnt  <= cfg_delay;
               end
            end
            ST_ACTIVE: begin
               if (cmd_pause) pause_pend <= 1'b1;
               if (tick && in_delay) begin
                  if (dly_cnt == DLY_W'(1)) in_delay <= 1'b0;
                  else                      dly_cnt  <= dly_cnt - 1'b1;
               end
               if (starve) underrun_q <= 1'b1;
               if (finish) begin
                  state_q    <= (pause_pend | cmd_pause) ? ST_PAUSED : ST_IDLE;
                  pause_pend <= 1'b0;
               end
            end
            default: state_q <= ST_RESET;
         endcase
      end
   end

   a_r13_reset_wins : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |=> (state_q == ST_RESET));
   a_r2_reset_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RESET && !cmd_enable) |=> (state_q == ST_RESET));
   a_r10_pause_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PAUSED && !cmd_enable && !cmd_reset) |=> (state_q == ST_PAUSED));
   a_r9_pop_needs_data : assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> fifo_valid);
endmodule

// File: rtl/sstx_top.sv
module sstx_top
   import sstx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DLY_W     = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              cfg_clk_inv,
   input  logic              cfg_sync_low,
   input  logic              cfg_strobe_low,
   input  logic              cfg_edge_start,
   input  logic [DLY_W-1:0]  cfg_delay,
   input  logic              cmd_enable,
   input  logic              cmd_reset,
   input  logic              cmd_pause,
   input  logic              frame_sync,
   input  logic              fifo_valid,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              fifo_eop,
   output logic              fifo_pop,
   output logic              tx_data,
   output logic              tx_strobe,
   output logic              tx_underrun,
   output logic [1:0]        tx_state
);
   logic      tick, start_ok, load, shift, clear, ser_empty, strb_q;
   tx_state_e state_q;

   assign tick = cfg_clk_inv ? sclk_fall : sclk_rise;

   sstx_frame_start u_start (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sync_in(frame_sync),
      .cfg_sync_low(cfg_sync_low), .cfg_edge_start(cfg_edge_start),
      .start_ok(start_ok)
   );

   sstx_ctrl #(.DLY_W(DLY_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cmd_enable(cmd_enable), .cmd_reset(cmd_reset), .cmd_pause(cmd_pause),
      .cfg_delay(cfg_delay), .start_ok(start_ok),
      .fifo_valid(fifo_valid), .fifo_eop(fifo_eop), .ser_empty(ser_empty),
      .state_q(state_q), .load(load), .shift(shift), .clear(clear),
      .fifo_pop(fifo_pop), .underrun_q(tx_underrun)
   );

   sstx_serializer #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_ser (
      .clk(clk), .rst_n(rst_n), .load(load), .shift(shift), .clear(clear),
      .data_in(fifo_data), .line_q(tx_data), .strb_q(strb_q), .empty(ser_empty)
   );

   assign tx_strobe = strb_q ^ cfg_strobe_low;
   assign tx_state  = state_q;

   a_r7_strobe_only_active : assert property (@(posedge clk) disable iff (!rst_n)
      strb_q |-> (state_q == ST_ACTIVE));
   a_r7_line_quiet_without_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      !strb_q |-> !tx_data);
endmodule

// File: tb/tb_sstx_top.sv
`timescale 1ns/1ps
module tb_sstx_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk_rise = 0, sclk_fall = 0;
   logic cfg_clk_inv = 0, cfg_sync_low = 0, cfg_strobe_low = 0, cfg_edge_start = 0;
   logic [1:0] cfg_delay = 2'd0;
   logic cmd_enable = 0, cmd_reset = 0, cmd_pause = 0;
   logic frame_sync = 0;
   logic fifo_valid, fifo_eop, fifo_pop;
   logic [7:0] fifo_data;
   logic tx_data, tx_strobe, tx_underrun;
   logic [1:0] tx_state;

   int checks = 0;
   int fails  = 0;

   logic [8:0] fmem [0:63];
   logic [5:0] wr = '0;
   logic [5:0] rd = '0;
   assign fifo_valid = (wr != rd);
   assign fifo_data  = fmem[rd][7:0];
   assign fifo_eop   = fmem[rd][8];
   always @(posedge clk) if (fifo_pop) rd <= rd + 1'b1;

   always #2 clk = ~clk;

   sstx_top dut (
      .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .cfg_clk_inv(cfg_clk_inv), .cfg_sync_low(cfg_sync_low),
      .cfg_strobe_low(cfg_strobe_low), .cfg_edge_start(cfg_edge_start),
      .cfg_delay(cfg_delay), .cmd_enable(cmd_enable), .cmd_reset(cmd_reset),
      .cmd_pause(cmd_pause), .frame_sync(frame_sync), .fifo_valid(fifo_valid),
      .fifo_data(fifo_data), .fifo_eop(fifo_eop), .fifo_pop(fifo_pop),
      .tx_data(tx_data), .tx_strobe(tx_strobe), .tx_underrun(tx_underrun),
      .tx_state(tx_state)
   );

   function automatic int fcount();
      return int'(6'(wr - rd));
   endfunction

   function automatic logic pin(input logic active);
      return active ^ cfg_strobe_low;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b, input logic eop);
      @(negedge clk);
      fmem[wr] = {eop, b};
      wr = wr + 1'b1;
   endtask

   // one serial tick on the chosen edge input, optionally with commands in the same cycle
   task automatic tk(input bit fall, input bit en = 0, input bit rs = 0, input bit pz = 0);
      @(negedge clk);
      if (fall) sclk_fall = 1'b1; else sclk_rise = 1'b1;
      cmd_enable = en; cmd_reset = rs; cmd_pause = pz;
      @(negedge clk);
      sclk_fall = 0; sclk_rise = 0; cmd_enable = 0; cmd_reset = 0; cmd_pause = 0;
   endtask

   task automatic cmd(input bit en, input bit rs, input bit pz);
      @(negedge clk);
      cmd_enable = en; cmd_reset = rs; cmd_pause = pz;
      @(negedge clk);
      cmd_enable = 0; cmd_reset = 0; cmd_pause = 0;
   endtask

   task automatic bits(input logic [7:0] b, input string tag);
      for (int i = 7; i >= 0; i--) begin
         tk(cfg_clk_inv);
         chk({tag, " strobe"}, tx_strobe, pin(1'b1));
         chk({tag, " data"}, tx_data, b[i]);
      end
   endtask

   task automatic end_tick(input string tag, input int exp_state);
      tk(cfg_clk_inv);
      chk({tag, " end strobe"}, tx_strobe, pin(1'b0));
      chk({tag, " end data"}, tx_data, 0);
      chk({tag, " end state"}, tx_state, exp_state);
   endtask

   task automatic t_reset();
      chk("R1 state after rst_n", tx_state, 0);
      chk("R1 strobe after rst_n", tx_strobe, 0);
      chk("R1 data after rst_n", tx_data, 0);
      chk("R1 underrun after rst_n", tx_underrun, 0);
   endtask

   task automatic t_enable();
      frame_sync = 1'b1;
      push(8'h11, 1'b1);
      tk(0);
      chk("R2 no start in reset state", tx_state, 0);
      chk("R2 no pop in reset state", fcount(), 1);
      frame_sync = 1'b0;
      cmd(1, 0, 0);
      chk("R2 enable leaves reset", tx_state, 1);
      cmd(1, 0, 0);
      chk("R2 enable ignored in idle", tx_state, 1);
      rd = wr;
   endtask

   task automatic t_level_nodelay();
      push(8'hA5, 1'b0);
      push(8'h3C, 1'b1);
      frame_sync = 1'b1;
      bits(8'hA5, "R6 R7 level D0 byte0");
      chk("R6 state active", tx_state, 2);
      bits(8'h3C, "R7 byte1");
      end_tick("R7 packet end", 1);
      chk("R7 queue drained", fcount(), 0);
   endtask

   task automatic t_edge_delay();
      cfg_edge_start = 1; cfg_sync_low = 1; cfg_delay = 2'd2;
      frame_sync = 1'b1;                         // inactive (active low)
      push(8'h81, 1'b1);
      tk(0);
      chk("R5 high level inactive when active low", tx_state, 1);
      frame_sync = 1'b0;                         // edge to active
      tk(0);
      chk("R4 edge starts frame", tx_state, 2);
      chk("R6 delay tick0 strobe", tx_strobe, pin(0));
      tk(0);
      chk("R6 delay tick1 strobe", tx_strobe, pin(0));
      bits(8'h81, "R6 delayed byte");
      end_tick("R7 delayed end", 1);
      push(8'h42, 1'b1);
      for (int i = 0; i < 3; i++) tk(0);
      chk("R4 held level gives no new start", tx_state, 1);
      chk("R4 held level no pop", fcount(), 1);
      rd = wr;
      cfg_edge_start = 0; cfg_sync_low = 0; cfg_delay = 2'd0; frame_sync = 0;
   endtask

   task automatic t_clk_inv();
      cfg_clk_inv = 1; cfg_strobe_low = 1;
      @(negedge clk);
      chk("R8 idle strobe pin high when active low", tx_strobe, 1);
      frame_sync = 1'b1;
      push(8'hF0, 1'b1);
      tk(0);
      chk("R3 rising tick ignored when inverted", tx_state, 1);
      chk("R3 no pop on ignored tick", fcount(), 1);
      bits(8'hF0, "R3 R8 falling edge byte");
      end_tick("R3 falling end", 1);
      cfg_clk_inv = 0; cfg_strobe_low = 0; frame_sync = 0;
   endtask

   task automatic t_underrun();
      frame_sync = 1'b1;
      push(8'hFF, 1'b0);
      bits(8'hFF, "R9 first byte");
      frame_sync = 1'b0;
      tk(0);
      chk("R9 starve strobe", tx_strobe, 0);
      chk("R9 starve data", tx_data, 0);
      chk("R9 underrun raised", tx_underrun, 1);
      chk("R9 still active", tx_state, 2);
      tk(0);
      chk("R9 second starve tick state", tx_state, 2);
      push(8'h01, 1'b1);
      bits(8'h01, "R9 resumed byte");
      end_tick("R9 resumed end", 1);
      chk("R9 underrun sticky", tx_underrun, 1);
   endtask

   task automatic t_pause_coincident();
      push(8'h55, 1'b1);
      push(8'hAA, 1'b1);
      frame_sync = 1'b1;
      bits(8'h55, "R10 packet A");
      tk(0, 0, 0, 1);                            // pause on the end tick itself
      chk("R10 coincident pause state", tx_state, 3);
      chk("R10 coincident pause strobe", tx_strobe, 0);
      chk("R10 next packet left", fcount(), 1);
      for (int i = 0; i < 3; i++) tk(0);
      chk("R10 paused holds", tx_state, 3);
      chk("R10 paused no pop", fcount(), 1);
   endtask

   task automatic t_resume_and_idle_pause();
      cmd(1, 0, 0);
      chk("R12 enable from paused", tx_state, 1);
      tk(0);
      chk("R12 head packet bit7 strobe", tx_strobe, 1);
      chk("R12 head packet bit7 data", tx_data, 1);
      tk(0); chk("R12 bit6", tx_data, 0);
      cmd(0, 0, 1);                              // early pause mid packet
      cmd(1, 0, 0);                              // enable while active: ignored
      chk("R2 enable ignored while active", tx_state, 2);
      tk(0); chk("R10 bit5 after early pause", tx_data, 1);
      tk(0); chk("R2 bit4 after ignored enable", tx_data, 0);
      tk(0); tk(0); tk(0); tk(0);
      chk("R10 bit0 still sent", tx_data, 0);
      end_tick("R10 early pause end", 3);
      cmd(1, 0, 0);
      frame_sync = 1'b0;
      cmd(0, 0, 1);
      chk("R11 pause in idle immediate", tx_state, 3);
      push(8'h99, 1'b1);
      frame_sync = 1'b1;
      tk(0);
      chk("R11 no start while paused", tx_state, 3);
      chk("R11 no pop while paused", fcount(), 1);
   endtask

   task automatic t_abort();
      cmd(1, 0, 0);
      tk(0); tk(0); tk(0);
      chk("R13 frame running", tx_state, 2);
      tk(0, 1, 1, 0);                            // reset with enable and a tick
      chk("R13 reset wins state", tx_state, 0);
      chk("R13 strobe off", tx_strobe, 0);
      chk("R13 data off", tx_data, 0);
      chk("R1 underrun cleared by reset cmd", tx_underrun, 0);
      push(8'h77, 1'b1);
      tk(0); tk(0);
      chk("R13 no pop after abort", fcount(), 1);
      chk("R13 stays reset", tx_state, 0);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_level_nodelay();
      t_edge_delay();
      t_clk_inv();
      t_underrun();
      t_pause_coincident();
      t_resume_and_idle_pause();
      t_abort();
      finish_run();
   end
endmodule